// File: doc/BRIEF.md
# Paired Row/Column DRAM Command Arbiter

This block sits between a DRAM controller's dependency scoreboard and the PHY-facing command path. On every controller cycle it looks at two ready vectors, one for row-class commands (activate, precharge) and one for column-class commands (read, write). From them it builds a command bundle that holds one row slot and one column slot. Both slots are filled in the same cycle. In half-rate operation the two commands share one controller cycle as single-slot commands. In quarter-rate operation each command spans two PHY slots.

Within each class the oldest ready entry is chosen. Age comes from the scoreboard's allocation head pointer, because entries are allocated in circular order. The column slot is chosen first. A row command that targets the bank of the chosen column command yields to it. Activates are held off while the global timer reports that an activate is not allowed. Each grant returns to the scoreboard in the same cycle as a one-hot acknowledge. The bundle is registered and appears on the cycle after the grant. The rate mode is a static configuration input that is captured only while reset is asserted.

Top module: `cab_arbiter`

## Requirements
- R1: A row acknowledge or column acknowledge is only given to an entry whose ready bit in that class is set, and each acknowledge vector has at most one bit set.
- R2: Among ready column entries, the acknowledge goes to the first ready entry found by searching upward from the head pointer, wrapping from entry N-1 to entry 0.
- R3: Among eligible row entries, the acknowledge goes to the first eligible entry found by the same upward, wrapping search from the head pointer.
- R4: While act_ok is low, no row entry marked as an activate is acknowledged. Precharge entries remain eligible.
- R5: When a column command is granted, a row entry whose bank equals the granted column entry's bank is not eligible in that cycle.
- R6: A slot with no grant carries the no-operation code 0, with index 0 and bank 0.
- R7: On the clock edge after a grant, the bundle shows the granted command: row code 1 for an activate and 2 for a precharge, column code 1 for a read and 2 for a write. The bundle also shows the granted entry index and that entry's bank.
- R8: In half-rate mode the row slot position is 0 and the column slot position is 1. In quarter-rate mode the row slot position is 0 and the column slot position is 2.
- R9: cfg_quarter is captured only while rst_n is low. Changing it after reset has no effect on the slot positions.
- R10: After reset, both bundle slots carry the no-operation code with index 0 and bank 0.
- R11: Both slots are filled in the same cycle whenever candidates exist. If any column entry is ready, a column acknowledge is given. If any row entry is eligible, a row acknowledge is given alongside it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_quarter | input | 1 | Rate mode, 1 = quarter rate, captured during reset |
| head_ptr | input | IW | Index of the oldest scoreboard entry |
| row_rdy | input | N | Row-class ready bit per entry |
| row_act | input | N | Per entry: 1 = activate, 0 = precharge |
| col_rdy | input | N | Column-class ready bit per entry |
| col_wr | input | N | Per entry: 1 = write, 0 = read |
| entry_bank | input | N*BW | Bank of each entry, entry i at bits i*BW +: BW |
| act_ok | input | 1 | Global timer allows an activate this cycle |
| row_ack | output | N | One-hot row grant to the scoreboard |
| col_ack | output | N | One-hot column grant to the scoreboard |
| bun_row_cmd | output | 2 | Row slot code: 0 NOP, 1 activate, 2 precharge |
| bun_row_idx | output | IW | Entry index in the row slot |
| bun_row_bank | output | BW | Bank in the row slot |
| bun_row_slot | output | 2 | PHY slot position of the row command |
| bun_col_cmd | output | 2 | Column slot code: 0 NOP, 1 read, 2 write |
| bun_col_idx | output | IW | Entry index in the column slot |
| bun_col_bank | output | BW | Bank in the column slot |
| bun_col_slot | output | 2 | PHY slot position of the column command |

## Verification
The bench targets the wraparound of the oldest-first search. A picker that ignores the head pointer, or does not wrap, grants the lowest-numbered entry instead of the oldest. It drives activate-only row traffic while act_ok is low. A missing veto would issue an activate that violates the timing window, and an over-wide veto would also stall precharges. It sets up a row command on the same bank as the granted column command, which catches a design that lets the row slot close or open the bank being accessed. It also changes the mode input after reset, which exposes a mode path that is not latched and moves the column slot position while traffic is running.

// File: rtl/cab_pkg.sv
// Shared encodings for the paired command arbiter.
// Assumes a two-bit code field per bundle slot.
package cab_pkg;
    typedef enum logic [1:0] {
        ROW_NOP = 2'd0,
        ROW_ACT = 2'd1,
        ROW_PRE = 2'd2
    } row_cmd_e;

    typedef enum logic [1:0] {
        COL_NOP = 2'd0,
        COL_RD  = 2'd1,
        COL_WR  = 2'd2
    } col_cmd_e;

    localparam logic [1:0] SLOT_ROW      = 2'd0;
    localparam logic [1:0] SLOT_COL_HALF = 2'd1;
    localparam logic [1:0] SLOT_COL_QTR  = 2'd2;
endpackage

// File: rtl/cab_oldest_pick.sv
// Oldest-first picker: returns the first requesting entry found by
// searching upward from the head index with wraparound.
// Assumes entries are allocated in circular order, so the head is oldest.
module cab_oldest_pick #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic [IW-1:0] head,
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx,
    output logic [N-1:0]  gnt
);
    // Rotating priority search starting at head.
    always_comb begin
        int pos;
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < N; i++) begin
            pos = (int'(head) + i) % N;
            if (!found && req[pos]) begin
                found = 1'b1;
                idx   = IW'(pos);
            end
        end
        gnt = found ? (N'(1) << idx) : '0;
    end
endmodule

// File: rtl/cab_bundle_reg.sv
// Output register for the command bundle; every field clears to NOP on reset.
// Assumes the caller already zeroes index and bank for empty slots.
module cab_bundle_reg #(
    parameter int IW = 3,
    parameter int BW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    row_cmd_d,
    input  logic [IW-1:0] row_idx_d,
    input  logic [BW-1:0] row_bank_d,
    input  logic [1:0]    col_cmd_d,
    input  logic [IW-1:0] col_idx_d,
    input  logic [BW-1:0] col_bank_d,
    output logic [1:0]    row_cmd_q,
    output logic [IW-1:0] row_idx_q,
    output logic [BW-1:0] row_bank_q,
    output logic [1:0]    col_cmd_q,
    output logic [IW-1:0] col_idx_q,
    output logic [BW-1:0] col_bank_q
);
    // Capture the next bundle each controller cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_cmd_q  <= '0;
            row_idx_q  <= '0;
            row_bank_q <= '0;
            col_cmd_q  <= '0;
            col_idx_q  <= '0;
            col_bank_q <= '0;
        end else begin
            row_cmd_q  <= row_cmd_d;
            row_idx_q  <= row_idx_d;
            row_bank_q <= row_bank_d;
            col_cmd_q  <= col_cmd_d;
            col_idx_q  <= col_idx_d;
            col_bank_q <= col_bank_d;
        end
    end
endmodule

// File: rtl/cab_arbiter.sv
// Paired row/column command arbiter. It picks the oldest ready column
// command, then the oldest eligible row command. A row command is
// eligible when it is ready, passes the activate veto and avoids the
// column winner's bank. Acknowledges are combinational; the bundle is
// registered. Assumes the scoreboard drops ready on the cycle after an
// acknowledge, and that cfg_quarter is static outside reset.
module cab_arbiter
    import cab_pkg::*;
#(
    parameter int N  = 8,
    parameter int BW = 3,
    localparam int IW = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_quarter,
    input  logic [IW-1:0]   head_ptr,
    input  logic [N-1:0]    row_rdy,
    input  logic [N-1:0]    row_act,
    input  logic [N-1:0]    col_rdy,
    input  logic [N-1:0]    col_wr,
    input  logic [N*BW-1:0] entry_bank,
    input  logic            act_ok,
    output logic [N-1:0]    row_ack,
    output logic [N-1:0]    col_ack,
    output logic [1:0]      bun_row_cmd,
    output logic [IW-1:0]   bun_row_idx,
    output logic [BW-1:0]   bun_row_bank,
    output logic [1:0]      bun_row_slot,
    output logic [1:0]      bun_col_cmd,
    output logic [IW-1:0]   bun_col_idx,
    output logic [BW-1:0]   bun_col_bank,
    output logic [1:0]      bun_col_slot
);
    logic          mode_q;
    logic          col_found, row_found;
    logic [IW-1:0] col_idx, row_idx;
    logic [N-1:0]  col_gnt, row_gnt, row_elig;
    logic [BW-1:0] col_bank, row_bank;
    logic [1:0]    row_cmd_d, col_cmd_d;

    // Latch the rate mode only while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= cfg_quarter;
    end

    cab_oldest_pick #(.N(N), .IW(IW)) u_col_pick (
        .head(head_ptr), .req(col_rdy),
        .found(col_found), .idx(col_idx), .gnt(col_gnt)
    );

    // Bank of the column winner, used to block conflicting row commands.
    always_comb col_bank = entry_bank[col_idx*BW +: BW];

    // Per-entry row eligibility: ready, not vetoed, no bank clash.
    for (genvar g = 0; g < N; g++) begin : g_elig
        always_comb
            row_elig[g] = row_rdy[g]
                        && !(row_act[g] && !act_ok)
                        && !(col_found && (entry_bank[g*BW +: BW] == col_bank));
    end

    cab_oldest_pick #(.N(N), .IW(IW)) u_row_pick (
        .head(head_ptr), .req(row_elig),
        .found(row_found), .idx(row_idx), .gnt(row_gnt)
    );

    // Acknowledges back to the scoreboard in the grant cycle.
    always_comb begin
        row_ack = row_gnt;
        col_ack = col_gnt;
    end

    // Form the next bundle codes from the winners.
    always_comb begin
        row_bank  = entry_bank[row_idx*BW +: BW];
        row_cmd_d = !row_found   ? ROW_NOP :
                    row_act[row_idx] ? ROW_ACT : ROW_PRE;
        col_cmd_d = !col_found   ? COL_NOP :
                    col_wr[col_idx]  ? COL_WR  : COL_RD;
    end

    cab_bundle_reg #(.IW(IW), .BW(BW)) u_bundle (
        .clk(clk), .rst_n(rst_n),
        .row_cmd_d(row_cmd_d),
        .row_idx_d(row_found ? row_idx : '0),
        .row_bank_d(row_found ? row_bank : '0),
        .col_cmd_d(col_cmd_d),
        .col_idx_d(col_found ? col_idx : '0),
        .col_bank_d(col_found ? col_bank : '0),
        .row_cmd_q(bun_row_cmd), .row_idx_q(bun_row_idx),
        .row_bank_q(bun_row_bank),
        .col_cmd_q(bun_col_cmd), .col_idx_q(bun_col_idx),
        .col_bank_q(bun_col_bank)
    );

    // Slot positions follow the latched rate mode.
    always_comb begin
        bun_row_slot = SLOT_ROW;
        bun_col_slot = mode_q ? SLOT_COL_QTR : SLOT_COL_HALF;
    end
endmodule

// File: rtl/cab_arbiter_chk.sv
// Property checker for cab_arbiter, attached with bind.
// Assumes it observes the arbiter's ports and its latched mode.
module cab_arbiter_chk #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] row_rdy,
    input logic [N-1:0] row_act,
    input logic [N-1:0] col_rdy,
    input logic         act_ok,
    input logic [N-1:0] row_ack,
    input logic [N-1:0] col_ack,
    input logic [1:0]   bun_row_cmd,
    input logic [1:0]   bun_col_cmd,
    input logic [1:0]   bun_col_slot
);
    AST_ROW_ONLY_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (row_ack & ~row_rdy) == '0); // R1
    AST_COL_ONLY_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (col_ack & ~col_rdy) == '0); // R1
    AST_ROW_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(row_ack)); // R1
    AST_COL_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(col_ack)); // R1
    AST_ACT_VETO: assert property (@(posedge clk) disable iff (!rst_n)
        !act_ok |-> (row_ack & row_act) == '0); // R4
    AST_COL_FILLED: assert property (@(posedge clk) disable iff (!rst_n)
        (|col_rdy) |-> (|col_ack)); // R11
    AST_COL_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        !(|col_ack) |=> bun_col_cmd == 2'd0); // R6
    AST_ROW_BUNDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (|row_ack) |=> bun_row_cmd != 2'd0); // R7
    AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(bun_col_slot)); // R9
endmodule

bind cab_arbiter cab_arbiter_chk #(.N(N)) u_chk (
    .clk(clk), .rst_n(rst_n), .row_rdy(row_rdy), .row_act(row_act),
    .col_rdy(col_rdy), .act_ok(act_ok), .row_ack(row_ack),
    .col_ack(col_ack), .bun_row_cmd(bun_row_cmd),
    .bun_col_cmd(bun_col_cmd), .bun_col_slot(bun_col_slot)
);

// File: tb/cab_arbiter_tb.sv
// Self-checking bench for cab_arbiter: seeded random traffic plus directed cases.
module cab_arbiter_tb;
    localparam int N  = 8;
    localparam int BW = 3;
    localparam int IW = $clog2(N);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_quarter = 1'b0;
    logic [IW-1:0]   head_ptr = '0;
    logic [N-1:0]    row_rdy = '0, row_act = '0, col_rdy = '0, col_wr = '0;
    logic [N*BW-1:0] entry_bank = '0;
    logic            act_ok = 1'b1;
    logic [N-1:0]    row_ack, col_ack;
    logic [1:0]      bun_row_cmd, bun_col_cmd, bun_row_slot, bun_col_slot;
    logic [IW-1:0]   bun_row_idx, bun_col_idx;
    logic [BW-1:0]   bun_row_bank, bun_col_bank;

    int n_tests = 0, n_fail = 0;
    bit done = 1'b0;
    int e_rcmd = 0, e_ridx = 0, e_rbank = 0, e_ccmd = 0, e_cidx = 0, e_cbank = 0;
    int e_cslot = 1;
    string bun_tag = "R7";
    string slot_tag = "R8";

    always #4 clk = ~clk;   // 125 MHz

    cab_arbiter #(.N(N), .BW(BW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_quarter(cfg_quarter), .head_ptr(head_ptr),
        .row_rdy(row_rdy), .row_act(row_act), .col_rdy(col_rdy), .col_wr(col_wr),
        .entry_bank(entry_bank), .act_ok(act_ok), .row_ack(row_ack), .col_ack(col_ack),
        .bun_row_cmd(bun_row_cmd), .bun_row_idx(bun_row_idx), .bun_row_bank(bun_row_bank),
        .bun_row_slot(bun_row_slot), .bun_col_cmd(bun_col_cmd), .bun_col_idx(bun_col_idx),
        .bun_col_bank(bun_col_bank), .bun_col_slot(bun_col_slot)
    );

    task automatic check(string tag, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int bank_of(int e);
        return int'(entry_bank[e*BW +: BW]);
    endfunction

    // Expected column winner: first ready entry at or after head, wrapping.
    function automatic int model_col();
        for (int i = 0; i < N; i++) begin
            int p = (int'(head_ptr) + i) % N;
            if (col_rdy[p]) return p;
        end
        return -1;
    endfunction

    // Expected row winner given the column winner.
    function automatic int model_row(int cw);
        for (int i = 0; i < N; i++) begin
            int p = (int'(head_ptr) + i) % N;
            if (row_rdy[p] && !(row_act[p] && !act_ok) &&
                !(cw >= 0 && bank_of(p) == bank_of(cw))) return p;
        end
        return -1;
    endfunction

    task automatic step(int h, logic [N-1:0] rr, logic [N-1:0] ra, logic [N-1:0] cr,
                        logic [N-1:0] cw_v, logic [N*BW-1:0] bk, logic ok);
        int ec, er;
        @(negedge clk);
        // Bundle registered at the last edge.
        check(bun_tag, int'(bun_row_cmd), e_rcmd);
        check(bun_tag, int'(bun_row_idx), e_ridx);
        check(bun_tag, int'(bun_row_bank), e_rbank);
        check(bun_tag, int'(bun_col_cmd), e_ccmd);
        check(bun_tag, int'(bun_col_idx), e_cidx);
        check(bun_tag, int'(bun_col_bank), e_cbank);
        check(slot_tag, int'(bun_row_slot), 0);
        check(slot_tag, int'(bun_col_slot), e_cslot);
        head_ptr = IW'(h); row_rdy = rr; row_act = ra; col_rdy = cr;
        col_wr = cw_v; entry_bank = bk; act_ok = ok;
        #1;
        ec = model_col();
        er = model_row(ec);
        check("R2", int'(col_ack), ec < 0 ? 0 : (1 << ec));
        check("R3", int'(row_ack), er < 0 ? 0 : (1 << er));
        check("R1", int'((row_ack & ~row_rdy) | (col_ack & ~col_rdy)), 0);
        check("R11", int'(|col_ack), int'(|col_rdy));
        e_rcmd  = er < 0 ? 0 : (row_act[er] ? 1 : 2);
        e_ridx  = er < 0 ? 0 : er;
        e_rbank = er < 0 ? 0 : bank_of(er);
        e_ccmd  = ec < 0 ? 0 : (col_wr[ec] ? 2 : 1);
        e_cidx  = ec < 0 ? 0 : ec;
        e_cbank = ec < 0 ? 0 : bank_of(ec);
    endtask

    task automatic idle();
        step(0, '0, '0, '0, '0, '0, 1'b1);
    endtask

    task automatic do_reset(logic q);
        @(negedge clk);
        rst_n = 1'b0; cfg_quarter = q;
        head_ptr = '0; row_rdy = '0; col_rdy = '0; act_ok = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R10", int'(bun_row_cmd), 0);
        check("R10", int'(bun_col_cmd), 0);
        check("R10", int'(bun_row_idx) + int'(bun_col_idx), 0);
        e_rcmd = 0; e_ridx = 0; e_rbank = 0; e_ccmd = 0; e_cidx = 0; e_cbank = 0;
        e_cslot = q ? 2 : 1;
    endtask

    task automatic rand_run(int n);
        for (int k = 0; k < n; k++)
            step($urandom_range(0, N - 1), N'($urandom), N'($urandom),
                 N'($urandom) & N'($urandom), N'($urandom),
                 (N*BW)'({$urandom, $urandom}), $urandom_range(0, 3) != 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        do_reset(1'b0);
        rand_run(300);
        // R2: wraparound from head 6 picks entry 7 ahead of entry 1.
        step(6, '0, '0, 8'h82, '0, '0, 1'b1);
        check("R2", int'(col_ack), 8'h80);
        // R4: only activates ready while vetoed -> no row grant.
        step(0, 8'h05, 8'h05, '0, '0, '0, 1'b0);
        check("R4", int'(row_ack), 0);
        // R4: precharge still granted under veto.
        step(0, 8'h06, 8'h02, '0, '0, '0, 1'b0);
        check("R4", int'(row_ack), 8'h04);
        // R5: column entry 2 on bank 3, row entry 0 on bank 3, row entry 1 on bank 5.
        step(0, 8'h03, '0, 8'h04, 8'h04, 24'h000_0EB, 1'b1);
        check("R5", int'(row_ack), 8'h02);
        // R6: only column ready -> row slot NOP next cycle.
        step(3, '0, '0, 8'h10, '0, '0, 1'b1);
        bun_tag = "R6";
        idle();
        bun_tag = "R7";
        // R9: mode input changed after reset has no effect.
        cfg_quarter = 1'b1;
        slot_tag = "R9";
        rand_run(20);
        slot_tag = "R8";
        do_reset(1'b1);
        rand_run(300);
        idle();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule